// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block links two parallel buses, A and B, through two independent transfer paths. The forward path carries data from A to B, and the reverse path carries data from B to A. Each path has its own capture register, its own capture clock, a source select and a drive enable. A path drives the far bus with one of two sources: the live value of the near bus, or the byte its register captured last. Each register loads its near bus on every rising edge of its own clock, whatever the selects and enables are set to.

The buses are modelled without tri-state nets. For each bus the block receives an external value and an external-drive flag. It produces its own output value, an output-enable and a resolved bus value. The resolved value feeds the capture registers and the live paths. When both paths drive live data at the same time, the two buses form a loop. The loop holds its value after every external driver lets go, and no clock is needed for that. A level-sensitive keeper models this hold.

A synchronous reset clears each register on that register's own clock. The keeper has no reset. A per-bus clash flag shows when the block and an external driver enable the same bus together.

Top module: `dual_reg_xcvr`

## Requirements
- R1: Data passes unchanged and not inverted in every one of the W bit positions (W = 8 by default).
- R2: On each rising edge of `ab_clk` the forward register loads the resolved A value. On each rising edge of `ba_clk` the reverse register loads the resolved B value. Neither load depends on the selects or drive inputs, and a register changes only on its own clock edge.
- R3: Select value 0 means live and value 1 means stored. With `ab_hold_sel` = 0, B is driven with the live A value. With `ab_hold_sel` = 1, B is driven with the forward register. `ba_hold_sel` chooses the source for A in the same way.
- R4: `ab_drive` is active high: `b_out_en` = `ab_drive`. `ba_drive_n` is active low: `a_out_en` = NOT `ba_drive_n`.
- R5: With both paths disabled, each resolved bus equals its external value. Clock edges still capture those external values.
- R6: While the forward path drives B with live A, a `ba_clk` edge loads the A value into the reverse register, so both registers end up holding the same byte.
- R7: With both paths enabled and both selects live, both buses carry the same value. That value persists after all external drivers are released, with no clock edge.
- R8: With both paths enabled and both selects stored, B shows the forward register and A shows the reverse register at the same time.
- R9: While `rst` is high, a rising edge of a path's clock clears that path's register to zero.
- R10: A bus the block drives resolves to the block's output, and an undriven bus resolves to its external value. `a_clash` / `b_clash` is high exactly when the block and the external driver both enable that bus.
- R11: While the live loop of R7 is closed, an enabled external A driver sets the loop value. If A is not driven externally, an enabled external B driver sets it. With neither, the previous loop value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ab_clk | input | 1 | Forward register capture clock (rising edge) |
| ba_clk | input | 1 | Reverse register capture clock (rising edge) |
| rst | input | 1 | Synchronous active-high register clear |
| ab_hold_sel | input | 1 | Forward source: 0 live A, 1 forward register |
| ba_hold_sel | input | 1 | Reverse source: 0 live B, 1 reverse register |
| ab_drive | input | 1 | Forward drive enable, active high |
| ba_drive_n | input | 1 | Reverse drive enable, active low |
| a_ext | input | W | External value on bus A |
| a_ext_en | input | 1 | External driver enabled on bus A |
| b_ext | input | W | External value on bus B |
| b_ext_en | input | 1 | External driver enabled on bus B |
| a_out | output | W | Block output value for bus A |
| a_out_en | output | 1 | Block drives bus A |
| b_out | output | W | Block output value for bus B |
| b_out_en | output | 1 | Block drives bus B |
| a_bus | output | W | Resolved value of bus A |
| b_bus | output | W | Resolved value of bus B |
| a_clash | output | 1 | Block and external driver both enable bus A |
| b_clash | output | 1 | Block and external driver both enable bus B |

## Verification
The bench builds the block with the default width of 8. Its byte patterns are chosen so that across them every bit position carries both a 0 and a 1. A swapped, dropped or inverted bit line therefore shows up on the buses and in the register readbacks. The two capture clocks are pulsed separately by the bench. This exposes a register that loads on the wrong clock, loads with no edge, or is gated by a select or drive input. The ability to drive and release each bus externally gives access to the clash flags, the driver precedence inside the live loop, and the clock-free hold after release.

// File: rtl/dxr_pkg.sv
package dxr_pkg;

    localparam int XCVR_W = 8;
    localparam int N_DIR  = 2;
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;

    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } src_e;

    typedef struct packed {
        src_e src;
        logic drive;
    } dir_ctl_t;

    // A path forwards the near bus straight through.
    function automatic logic passes_live(dir_ctl_t c);
        return c.drive && (c.src == SRC_LIVE);
    endfunction

    // Both paths forward live data: the buses feed each other.
    function automatic logic loop_closed(dir_ctl_t ab, dir_ctl_t ba);
        return passes_live(ab) && passes_live(ba);
    endfunction

endpackage

// File: rtl/dxr_dir_reg.sv
module dxr_dir_reg #(
    parameter int W = dxr_pkg::XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R9: reset edge clears the register
    p_reset_clear_r9: assert property (@(posedge clk) rst |=> (q == '0));

    // R2: each own-clock edge loads the bus value seen at that edge
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q == $past(d)));

endmodule

// File: rtl/dxr_bus_net.sv
module dxr_bus_net #(
    parameter int W = dxr_pkg::XCVR_W
) (
    input  logic         blk_en,
    input  logic [W-1:0] blk_val,
    input  logic         ext_en,
    input  logic [W-1:0] ext_val,
    input  logic [W-1:0] bus,
    output logic         clash
);

    assign clash = blk_en & ext_en;

    // R10: the resolved bus follows the block when it drives, else the outside
    always_comb begin
        if (blk_en) begin
            p_drive_wins_r10: assert (bus == blk_val);
        end else begin
            p_ext_passes_r10: assert (bus == ext_val);
        end
    end

endmodule

// File: rtl/dxr_fabric.sv
module dxr_fabric
    import dxr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  dir_ctl_t     ctl_ab,
    input  dir_ctl_t     ctl_ba,
    input  logic [W-1:0] reg_ab,
    input  logic [W-1:0] reg_ba,
    input  logic [W-1:0] a_ext,
    input  logic         a_ext_en,
    input  logic [W-1:0] b_ext,
    input  logic         b_ext_en,
    output logic [W-1:0] a_val,
    output logic [W-1:0] b_val,
    output logic [W-1:0] a_bus,
    output logic [W-1:0] b_bus
);

    logic         loop;
    logic         ext_any;
    logic [W-1:0] a_base, b_base;
    logic [W-1:0] a_open, b_open;
    logic [W-1:0] seed;
    logic [W-1:0] keep;
    logic [W-1:0] loop_val;

    assign loop    = loop_closed(ctl_ab, ctl_ba);
    assign ext_any = a_ext_en | b_ext_en;
    assign seed    = a_ext_en ? a_ext : b_ext;

    // Value on each bus when its own path is not forwarding live data.
    assign a_base = ctl_ba.drive ? reg_ba : a_ext;
    assign b_base = ctl_ab.drive ? reg_ab : b_ext;

    // Open (non-loop) resolution: at most one side forwards live data.
    assign a_open = passes_live(ctl_ba) ? b_base : a_base;
    assign b_open = passes_live(ctl_ab) ? a_base : b_base;

    // Clock-free hold of the closed live loop.
    always_latch begin
        if (!loop || ext_any) keep <= loop ? seed : a_open;
    end

    assign loop_val = ext_any ? seed : keep;
    assign a_bus    = loop ? loop_val : a_open;
    assign b_bus    = loop ? loop_val : b_open;

    assign a_val = (ctl_ba.src == SRC_HELD) ? reg_ba : b_bus;
    assign b_val = (ctl_ab.src == SRC_HELD) ? reg_ab : a_bus;

    always_comb begin
        // R7: a closed live loop shows one value on both buses
        if (loop) begin
            p_loop_agree_r7: assert (a_bus == b_bus);
        end
        // R8: both stored paths show their registers together
        if (ctl_ab.drive && ctl_ba.drive &&
            ctl_ab.src == SRC_HELD && ctl_ba.src == SRC_HELD) begin
            p_stored_pair_r8: assert (a_bus == reg_ba && b_bus == reg_ab);
        end
        // R5: isolated buses keep their outside values
        if (!ctl_ab.drive && !ctl_ba.drive) begin
            p_isolated_r5: assert (a_bus == a_ext && b_bus == b_ext);
        end
    end

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
    import dxr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         ab_clk,
    input  logic         ba_clk,
    input  logic         rst,
    input  logic         ab_hold_sel,
    input  logic         ba_hold_sel,
    input  logic         ab_drive,
    input  logic         ba_drive_n,
    input  logic [W-1:0] a_ext,
    input  logic         a_ext_en,
    input  logic [W-1:0] b_ext,
    input  logic         b_ext_en,
    output logic [W-1:0] a_out,
    output logic         a_out_en,
    output logic [W-1:0] b_out,
    output logic         b_out_en,
    output logic [W-1:0] a_bus,
    output logic [W-1:0] b_bus,
    output logic         a_clash,
    output logic         b_clash
);

    dir_ctl_t     ctl_ab, ctl_ba;
    logic [N_DIR-1:0] cap_clk;
    logic [W-1:0] cap_d [N_DIR];
    logic [W-1:0] cap_q [N_DIR];

    assign ctl_ab.src   = src_e'(ab_hold_sel);
    assign ctl_ab.drive = ab_drive;
    assign ctl_ba.src   = src_e'(ba_hold_sel);
    assign ctl_ba.drive = ~ba_drive_n;

    assign cap_clk[DIR_AB] = ab_clk;
    assign cap_clk[DIR_BA] = ba_clk;
    assign cap_d[DIR_AB]   = a_bus;
    assign cap_d[DIR_BA]   = b_bus;

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        dxr_dir_reg #(.W(W)) u_reg (
            .clk (cap_clk[g]),
            .rst (rst),
            .d   (cap_d[g]),
            .q   (cap_q[g])
        );
    end

    dxr_fabric #(.W(W)) u_fabric (
        .ctl_ab   (ctl_ab),
        .ctl_ba   (ctl_ba),
        .reg_ab   (cap_q[DIR_AB]),
        .reg_ba   (cap_q[DIR_BA]),
        .a_ext    (a_ext),
        .a_ext_en (a_ext_en),
        .b_ext    (b_ext),
        .b_ext_en (b_ext_en),
        .a_val    (a_out),
        .b_val    (b_out),
        .a_bus    (a_bus),
        .b_bus    (b_bus)
    );

    assign a_out_en = ctl_ba.drive;
    assign b_out_en = ctl_ab.drive;

    dxr_bus_net #(.W(W)) u_net_a (
        .blk_en  (a_out_en),
        .blk_val (a_out),
        .ext_en  (a_ext_en),
        .ext_val (a_ext),
        .bus     (a_bus),
        .clash   (a_clash)
    );

    dxr_bus_net #(.W(W)) u_net_b (
        .blk_en  (b_out_en),
        .blk_val (b_out),
        .ext_en  (b_ext_en),
        .ext_val (b_ext),
        .bus     (b_bus),
        .clash   (b_clash)
    );

endmodule

// File: tb/sim_dual_reg_xcvr.sv
module sim_dual_reg_xcvr;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         ab_clk = 1'b0, ba_clk = 1'b0, rst = 1'b1;
    logic         ab_hold_sel = 1'b0, ba_hold_sel = 1'b0;
    logic         ab_drive = 1'b0, ba_drive_n = 1'b1;
    logic [W-1:0] a_ext = '0, b_ext = '0;
    logic         a_ext_en = 1'b0, b_ext_en = 1'b0;
    logic [W-1:0] a_out, b_out, a_bus, b_bus;
    logic         a_out_en, b_out_en, a_clash, b_clash;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dual_reg_xcvr #(.W(W)) u0 (
        .ab_clk(ab_clk), .ba_clk(ba_clk), .rst(rst),
        .ab_hold_sel(ab_hold_sel), .ba_hold_sel(ba_hold_sel),
        .ab_drive(ab_drive), .ba_drive_n(ba_drive_n),
        .a_ext(a_ext), .a_ext_en(a_ext_en), .b_ext(b_ext), .b_ext_en(b_ext_en),
        .a_out(a_out), .a_out_en(a_out_en), .b_out(b_out), .b_out_en(b_out_en),
        .a_bus(a_bus), .b_bus(b_bus), .a_clash(a_clash), .b_clash(b_clash)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            bad  = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ctl(input logic abs, input logic bas, input logic abd, input logic bad_n);
        ab_hold_sel = abs; ba_hold_sel = bas; ab_drive = abd; ba_drive_n = bad_n;
        #2;
    endtask

    task automatic ext(input logic [W-1:0] av, input logic aen, input logic [W-1:0] bv, input logic ben);
        a_ext = av; a_ext_en = aen; b_ext = bv; b_ext_en = ben;
        #2;
    endtask

    task automatic pulse_ab();
        ab_clk = 1'b1; #4; ab_clk = 1'b0; #4;
    endtask

    task automatic pulse_ba();
        ba_clk = 1'b1; #4; ba_clk = 1'b0; #4;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        pulse_ab(); pulse_ba();
        rst = 1'b0;
        ctl(1, 1, 1, 0);
        chk("R9 fwd reg cleared", b_bus, 8'h00);
        chk("R9 rev reg cleared", a_bus, 8'h00);
    endtask

    task automatic t_isolate();
        ctl(0, 0, 0, 1);
        ext(8'h3C, 1, 8'hA5, 1);
        chk("R5 A isolated", a_bus, 8'h3C);
        chk("R5 B isolated", b_bus, 8'hA5);
        chk("R5 no drive", {6'b0, a_out_en, b_out_en}, 8'h00);
        pulse_ab(); pulse_ba();
        chk("R5 A after clocks", a_bus, 8'h3C);
        ext(8'h00, 0, 8'h00, 0);
        ctl(1, 1, 1, 0);
        chk("R5 fwd captured A", b_bus, 8'h3C);
        chk("R5 rev captured B", a_bus, 8'hA5);
        chk("R8 B out is fwd reg", b_out, 8'h3C);
    endtask

    task automatic t_live();
        ctl(0, 1, 1, 1);
        ext(8'h5A, 1, 8'h00, 0);
        chk("R3 live A to B", b_bus, 8'h5A);
        ext(8'h81, 1, 8'h00, 0);
        chk("R1 bits kept A to B", b_out, 8'h81);
        ctl(0, 0, 0, 0);
        ext(8'h00, 0, 8'h77, 1);
        chk("R3 live B to A", a_bus, 8'h77);
        ext(8'h00, 0, 8'h88, 1);
        chk("R1 bits kept B to A", a_out, 8'h88);
    endtask

    task automatic t_polarity();
        ctl(0, 0, 1, 1);
        chk("R4 fwd high drives B only", {6'b0, a_out_en, b_out_en}, 8'h01);
        ctl(0, 0, 0, 0);
        chk("R4 rev low drives A only", {6'b0, a_out_en, b_out_en}, 8'h02);
    endtask

    task automatic t_both_regs();
        ctl(0, 0, 1, 1);
        ext(8'hC3, 1, 8'h00, 0);
        pulse_ab(); pulse_ba();
        ext(8'h00, 0, 8'h00, 0);
        ctl(1, 1, 1, 0);
        chk("R6 fwd holds A", b_bus, 8'hC3);
        chk("R6 rev holds A", a_bus, 8'hC3);
    endtask

    task automatic t_capture_free();
        ctl(1, 1, 1, 1);
        ext(8'h19, 1, 8'h00, 0);
        chk("R2 no load before edge", b_bus, 8'hC3);
        pulse_ba();
        chk("R2 other clock leaves fwd", b_bus, 8'hC3);
        pulse_ab();
        chk("R2 stored mode still loads", b_bus, 8'h19);
        ctl(1, 1, 0, 1);
        ext(8'h2D, 1, 8'h00, 0);
        pulse_ab();
        ctl(1, 1, 1, 1);
        ext(8'h00, 0, 8'h00, 0);
        chk("R2 disabled path still loads", b_bus, 8'h2D);
    endtask

    task automatic t_clash();
        ctl(1, 1, 1, 1);
        ext(8'h00, 0, 8'hF0, 1);
        chk("R10 B clash set", {7'b0, b_clash}, 8'h01);
        chk("R10 B follows block", b_bus, 8'h2D);
        chk("R10 A no clash", {7'b0, a_clash}, 8'h00);
        ext(8'h00, 0, 8'h00, 0);
        chk("R10 B clash clear", {7'b0, b_clash}, 8'h00);
    endtask

    task automatic t_loop();
        ctl(0, 0, 1, 0);
        ext(8'h6E, 1, 8'h00, 0);
        chk("R7 loop B from A", b_bus, 8'h6E);
        chk("R10 A clash in loop", {7'b0, a_clash}, 8'h01);
        ext(8'h00, 0, 8'h00, 0);
        chk("R7 A held no clock", a_bus, 8'h6E);
        chk("R7 B held no clock", b_bus, 8'h6E);
        ext(8'h00, 0, 8'h11, 1);
        chk("R11 B driver sets loop", a_bus, 8'h11);
        ext(8'h22, 1, 8'h33, 1);
        chk("R11 A driver wins", b_bus, 8'h22);
        ext(8'h00, 0, 8'h00, 0);
        chk("R11 loop keeps last", a_bus, 8'h22);
        pulse_ba();
        ctl(1, 1, 1, 0);
        chk("R6 rev captured loop", a_bus, 8'h22);
    endtask

    initial begin
        #1;
        t_reset();
        t_isolate();
        t_live();
        t_polarity();
        t_both_regs();
        t_capture_free();
        t_clash();
        t_loop();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule